// File: doc/BRIEF.md
# PHY Indirect Register Access Bridge

This block lets a host reach a bank of 16-bit PHY configuration registers through a single 32-bit control word. The host sends one transaction by writing one word. That word holds the direction, an 8-bit register address and, for a write, 16 bits of data. The bridge then runs the access against the bank. The access takes a fixed number of clock cycles, set by a parameter. During that time a busy flag is set in the word.

The control word can be read back at any time. When a read finishes, the upper half of the word holds the value fetched from the addressed register. A command that arrives while an access is still running is discarded and sets a sticky error flag. Software is expected to poll the busy flag and to give up after a bounded time. The bridge completes every access in a fixed, short number of cycles, well within any such window.

The bank holds 48 entries at addresses 0x00 to 0x2F. Accesses outside that range are harmless: a write is dropped, and a read returns zero.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset, the control word reads 0x0000_0000. Busy, the error flag and all fields are zero.
- R2: A command word with bit 0 = 1 is a write. Bits 15:8 give the address and bits 31:16 the data. When the write completes, the addressed entry holds that data.
- R3: Busy (bit 7) reads 1 for exactly LATENCY cycles after a command is accepted, then reads 0. LATENCY is at least 2.
- R4: A command word with bit 0 = 0 is a read. When it completes, bits 31:16 hold the addressed entry's value, bits 15:8 hold the address and bit 0 reads 0. The word then stays unchanged until the next command.
- R5: A command presented while busy is 1 is ignored. It does not change the bank or the fields of the running command. It sets the error flag (bit 6) to 1.
- R6: The error flag stays at 1 until the next accepted command, which clears it in the same cycle that busy rises.
- R7: A write to an address of 0x30 or above changes no entry. A read from such an address returns 0x0000.
- R8: After reset, entry n holds the value 0xC300 | n.
- R9: While busy is 1, bits 31:8 and bit 0 of the control word show the accepted command word unchanged.
- R10: Bits 5:1 of the control word always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host writes cmd_word into the control word this cycle |
| cmd_word | input | 32 | Command: bit 0 direction, 15:8 address, 31:16 write data |
| ctrl_word | output | 32 | Readback: data 31:16, address 15:8, busy 7, error 6, direction 0 |

## Verification
The bench injects a second command in the middle of a running access. A bridge that accepted it would corrupt the target register or the shown address. A bridge that forgot it would leave the error flag clear. The bench also checks the first accepted command after a rejection: a bridge that kept the error flag set would fail there. A busy window that is off by one cycle is caught, because busy is sampled in every cycle of the access. Addresses just past the bank's end test the range limit: a bridge that aliased them into the bank would return a nonzero value or overwrite a low entry. Random mixes of reads and writes, compared against a model of the bank, would expose read data taken from the wrong entry, or data that shows up before the access completes.

// File: rtl/phy_ib_pkg.sv
package phy_ib_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int ERR_BIT  = 6;
    localparam int BUSY_BIT = 7;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              is_write;
    } phy_cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

    function automatic phy_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        phy_cmd_t c;
        c.data     = w[31:16];
        c.addr     = w[15:8];
        c.is_write = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input phy_cmd_t c,
                                                    input logic busy,
                                                    input logic err);
        return {c.data, c.addr, busy, err, 5'b00000, c.is_write};
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        return {8'hC3, 8'(idx)};
    endfunction

endpackage

// File: rtl/phy_ib_bank.sv
module phy_ib_bank
    import phy_ib_pkg::*;
#(
    parameter int DEPTH = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [DEPTH];
    logic [DEPTH-1:0]  hit;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hit
            assign hit[g] = (addr == ADDR_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                regs[i] <= reset_value(i);
            end else if (we && hit[i]) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit[i]) begin
                rdata = regs[i];
            end
        end
    end

endmodule

// File: rtl/phy_ib_seq.sv
module phy_ib_seq
    import phy_ib_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              bank_we,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic [WORD_W-1:0] ctrl_word
);

    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

    seq_state_e       state_q;
    phy_cmd_t         cmd_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             reject;
    logic             done;

    assign accept = cmd_valid && (state_q == ST_IDLE);
    assign reject = cmd_valid && (state_q == ST_BUSY);
    assign done   = (state_q == ST_BUSY) && (cnt_q == '0);

    assign bank_we    = done && cmd_q.is_write;
    assign bank_addr  = cmd_q.addr;
    assign bank_wdata = cmd_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (accept) begin
            state_q <= ST_BUSY;
            cmd_q   <= decode_cmd(cmd_word);
            err_q   <= 1'b0;
            cnt_q   <= CNT_LOAD;
        end else if (state_q == ST_BUSY) begin
            if (reject) begin
                err_q <= 1'b1;
            end
            if (done) begin
                state_q <= ST_IDLE;
                if (!cmd_q.is_write) begin
                    cmd_q.data <= bank_rdata;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ctrl_word = pack_word(cmd_q, state_q == ST_BUSY, err_q);

endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
    import phy_ib_pkg::*;
#(
    parameter int DEPTH   = 48,
    parameter int LATENCY = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output logic [31:0] ctrl_word
);

    logic              bank_we;
    logic [ADDR_W-1:0] bank_addr;
    logic [DATA_W-1:0] bank_wdata;
    logic [DATA_W-1:0] bank_rdata;

    phy_ib_seq #(.LATENCY(LATENCY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .bank_rdata (bank_rdata),
        .bank_we    (bank_we),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .ctrl_word  (ctrl_word)
    );

    phy_ib_bank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (bank_we),
        .addr  (bank_addr),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );

endmodule

// File: rtl/phy_ind_bridge_chk.sv
module phy_ind_bridge_chk #(
    parameter int LATENCY = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [31:0] ctrl_word
);

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (ctrl_word[7]) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    initial begin
        AST_LATENCY_MIN: assert (LATENCY >= 2); // R3
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctrl_word == 32'h0); // R1

    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_word[7]) |-> run_q == 16'(LATENCY)); // R3

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[7] |-> run_q < 16'(LATENCY)); // R3

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && ctrl_word[7] |=> ctrl_word[6]); // R5

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !ctrl_word[7] |=> ctrl_word[7] && !ctrl_word[6]); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[7] |=> $stable(ctrl_word[15:8]) && $stable(ctrl_word[0])); // R9

    AST_IDLE_STEADY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[7] && !cmd_valid |=> $stable(ctrl_word)); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[5:1] == 5'b0); // R10

endmodule

bind phy_ind_bridge phy_ind_bridge_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .ctrl_word (ctrl_word)
);

// File: tb/test_phy_ind_bridge.sv
`timescale 1ns/1ps
module test_phy_ind_bridge;

    localparam int LAT   = 4;
    localparam int DEPTH = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] ctrl_word;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model [DEPTH];

    always #2 clk = ~clk;

    phy_ind_bridge #(.DEPTH(DEPTH), .LATENCY(LAT)) i_phy_ind_bridge (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .ctrl_word (ctrl_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit wr, input logic [7:0] a, input logic [15:0] d);
        return {d, a, 7'b0, wr};
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        return (a < DEPTH) ? model[a] : 16'h0000;
    endfunction

    task automatic run_cmd(input logic [31:0] w, input bit inject, input logic [31:0] iw);
        bit busy_ok = 1'b1;
        logic [31:0] expw;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R6 error cleared on accept", {31'b0, ctrl_word[6]}, 32'h0);
        check("R9 command shown while busy", {ctrl_word[31:8], 7'b0, ctrl_word[0]},
              {w[31:8], 7'b0, w[0]});
        for (int k = 0; k < LAT; k++) begin
            if (!ctrl_word[7]) busy_ok = 1'b0;
            if (inject && k == 1) begin
                cmd_valid = 1'b1;
                cmd_word  = iw;
            end
            @(negedge clk);
            if (inject && k == 1) cmd_valid = 1'b0;
        end
        check("R3 busy held LATENCY cycles", {31'b0, busy_ok}, 32'h1);
        if (w[0]) begin
            if (w[15:8] < DEPTH) model[w[15:8]] = w[31:16];
            expw = {w[31:16], w[15:8], 1'b0, inject, 5'b0, 1'b1};
            check("R2 R10 write completion word", ctrl_word, expw);
        end else begin
            expw = {exp_read(w[15:8]), w[15:8], 1'b0, inject, 5'b0, 1'b0};
            check("R4 R7 R10 read completion word", ctrl_word, expw);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        int unsigned seed_dummy;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hC300 | 16'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset word", ctrl_word, 32'h0);

        // R8: reset contents
        run_cmd(mk(1'b0, 8'h2F, 16'h0), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'h00, 16'h0), 1'b0, 32'h0);

        // R2 then R4 readback
        run_cmd(mk(1'b1, 8'h09, 16'hBEEF), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'h09, 16'h0), 1'b0, 32'h0);

        // R4: word stays steady while idle
        hold = ctrl_word;
        repeat (5) @(negedge clk);
        check("R4 idle word steady", ctrl_word, hold);

        // R5: injected write while busy is ignored
        run_cmd(mk(1'b0, 8'h05, 16'h0), 1'b1, mk(1'b1, 8'h05, 16'hFFFF));
        check("R5 error flag set", {31'b0, ctrl_word[6]}, 32'h1);
        hold = ctrl_word;
        repeat (3) @(negedge clk);
        check("R5 error flag sticky", ctrl_word, hold);
        // R6 accepted command clears error, R5 bank untouched
        run_cmd(mk(1'b0, 8'h05, 16'h0), 1'b0, 32'h0);

        // R7: out-of-range
        run_cmd(mk(1'b1, 8'h30, 16'h1234), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'h30, 16'h0), 1'b0, 32'h0);
        run_cmd(mk(1'b1, 8'hFF, 16'h5555), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'hFF, 16'h0), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'h00, 16'h0), 1'b0, 32'h0);
        run_cmd(mk(1'b0, 8'h0F, 16'h0), 1'b0, 32'h0);

        // random mix
        seed_dummy = $urandom(32'd2024);
        for (int n = 0; n < 80; n++) begin
            logic [7:0]  a;
            logic [15:0] d;
            bit          wr;
            bit          inj;
            a   = 8'($urandom_range(0, 63));
            d   = 16'($urandom);
            wr  = 1'($urandom);
            inj = ($urandom_range(0, 7) == 0);
            run_cmd(mk(wr, a, d), inj, mk(1'b1, a ^ 8'h01, ~d));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule